// File: doc/BRIEF.md
# Adder-Based Up/Down Counter

A small counter whose next value is always produced by one adder. Each cycle the register's current value is added to an operand formed from the down request, with the up request entering as the adder's carry-in. A down request replicates into an all-ones operand, which is the two's-complement form of minus one. An up request contributes one through the carry. With neither request active, the sum equals the current value. The sum is written back into the register on every rising clock edge.

The count is WIDTH bits wide and defaults to 3. It wraps modulo 2^WIDTH in both directions. The reset is synchronous and active high. Asking to count up and down in the same cycle is outside the allowed input set, and a bound checker reports it.

Top module: `addsub_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count becomes 0 after that edge, whatever `inc_req` and `dec_req` are.
- R2: With `inc_req`=1 and `dec_req`=0, the count increases by one at the next rising edge.
- R3: With `inc_req`=0 and `dec_req`=1, the count decreases by one at the next rising edge. This is done by adding the all-ones operand.
- R4: With both requests 0, the count holds its value across the edge.
- R5: Counting up from the maximum value (all ones, 7 by default) gives 0.
- R6: Counting down from 0 gives the maximum value.
- R7: `inc_req` and `dec_req` are never both 1 in the same cycle, and the checker flags any cycle where they are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| inc_req | input | 1 | Count-up request, used as the adder carry-in |
| dec_req | input | 1 | Count-down request, replicated into the adder operand |
| count | output | WIDTH | Current count value |

## Verification
The assertions assume that the environment never raises both requests in the same cycle. R7 states this as a property. The arithmetic checks are only meaningful under that assumption, because with both requests high the adder would add zero. The bench picks each cycle's request from three legal codes (up, down, hold) drawn with `$urandom`, so the illegal pair is never produced. Directed sequences then walk the count across both wrap points and through reset.

// File: rtl/addsub_counter.sv
module addsub_counter #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_req,
  input  logic             dec_req,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] operand;
  logic [WIDTH-1:0] sum;

  assign operand = {WIDTH{dec_req}};
  assign sum     = count + operand + {{(WIDTH-1){1'b0}}, inc_req};

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= sum;
  end

endmodule

// File: rtl/addsub_counter_chk.sv
module addsub_counter_chk #(
  parameter int WIDTH = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             inc_req,
  input logic             dec_req,
  input logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> count == '0);

  assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
    (inc_req && !dec_req) |=> count == $past(count) + ONE);

  assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
    (!inc_req && dec_req) |=> count == $past(count) - ONE);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!inc_req && !dec_req) |=> $stable(count));

  assert_wrap_up_R5: assert property (@(posedge clk) disable iff (rst)
    (inc_req && !dec_req && count == '1) |=> count == '0);

  assert_wrap_down_R6: assert property (@(posedge clk) disable iff (rst)
    (!inc_req && dec_req && count == '0) |=> count == '1);

  assert_no_both_R7: assert property (@(posedge clk) disable iff (rst)
    !(inc_req && dec_req));

endmodule

bind addsub_counter addsub_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .inc_req(inc_req), .dec_req(dec_req), .count(count)
);

// File: tb/addsub_counter_tb.sv
module addsub_counter_tb;
  localparam int W = 3;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0;
  logic rst, inc, dec;
  logic [W-1:0] count;
  int total = 0;
  int bad = 0;
  logic [W-1:0] model;

  addsub_counter #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .inc_req(inc), .dec_req(dec), .count(count)
  );

  always #2 clk = ~clk;

  function automatic logic [W-1:0] next_val(logic [W-1:0] c, logic u, logic d);
    if (u) return (c == MAXV) ? '0 : c + 1'b1;
    if (d) return (c == 0) ? W'(MAXV) : c - 1'b1;
    return c;
  endfunction

  task automatic check(string req, logic [W-1:0] exp);
    total++;
    if (count !== exp) begin
      bad++;
      $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
    end
  endtask

  task automatic tag_of(logic u, logic d, logic [W-1:0] c, output string t);
    if (u) t = (c == MAXV) ? "R5" : "R2";
    else if (d) t = (c == 0) ? "R6" : "R3";
    else t = "R4";
  endtask

  task automatic step(logic u, logic d);
    string t;
    tag_of(u, d, model, t);
    inc = u; dec = d;
    @(posedge clk); #1;
    model = next_val(model, u, d);
    check(t, model);
  endtask

  task automatic do_reset(logic u, logic d);
    rst = 1; inc = u; dec = d;
    @(posedge clk); #1;
    rst = 0;
    model = '0;
    check("R1", '0);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: count=%0d expected=done", count);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    rst = 1; inc = 0; dec = 0;
    @(negedge clk);
    do_reset(1, 0);
    // R5 walk up through wrap
    for (int i = 0; i < 9; i++) step(1, 0);
    do_reset(0, 1);
    // R6 down from zero and full loop
    for (int i = 0; i < 9; i++) step(0, 1);
    for (int i = 0; i < 3; i++) step(0, 0);
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(2, 0);
      // R7: only legal codes
      if (r == 0) step(1, 0);
      else if (r == 1) step(0, 1);
      else step(0, 0);
    end
    for (int i = 0; i < 3; i++) step(1, 0);
    do_reset(0, 0);
    step(0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule